// File: doc/BRIEF.md
# Glitch Detector Control Register Bank

This block is the software-facing control and status bank that sits beside four supply or clock glitch detectors. A 32-bit register bus writes and reads six word registers. From them the bank derives three things. The first is the effective arm signal, which combines the nonvolatile arm default with software force-on and force-off keys. The second is the 2-bit sensitivity for each detector, taken from software only when it is paired with its bitwise complement and from the nonvolatile default otherwise. The third is a combined alarm that stays high while any sticky trigger flag is set.

Raw detector outputs and software-forced triggers set the trigger flags, but only while the detectors are armed. Software clears the flags by writing 1 to them. A write lock, once loaded with a nonzero value, freezes the arm, disarm and sensitivity registers until reset. The lock is a two-state machine. State `LK_OPEN` is the reset state. The transition `seal` moves it to `LK_SEALED` on a nonzero write to the lock register. `LK_SEALED` has only a self-transition `hold` and is left only through reset. The arm source is chosen among `SRC_FORCE_ON`, `SRC_FORCE_OFF` and `SRC_NV` in that priority.

Register layout by word index, taken from `bus_addr[4:2]`: 0 arm key, 1 disarm key, 2 sensitivity, 3 lock, 4 trigger flags, 5 force trigger. Indices 6 and 7 are unmapped. `bus_addr[1:0]` is ignored. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. `bus_rdata` is a combinational function of `bus_addr`.

Top module: `gdet_ctrl_bank`

## Requirements
- R1: After reset the arm word reads 0x00005BAD and every other word reads 0. `armed` equals `nv_arm_en`, `det_sens` equals `nv_sens`, and `alarm` is 0.
- R2: When the arm word holds any value in bits 15:0 other than 0x5BAD, `armed` is 1 regardless of `nv_arm_en`. Writing 0x5BAD back returns `armed` to the default selection.
- R3: When the arm word is 0x5BAD and the disarm word bits 15:0 equal 0xDCAF, `armed` is 0 even if `nv_arm_en` is 1. A forced arm wins over a forced disarm. Any other disarm value selects `nv_arm_en`.
- R4: Detector i uses sensitivity word bits [2i+1:2i] only when bits [9+2i:8+2i] are their exact bitwise complement. Otherwise it uses `nv_sens[2i+1:2i]`. The check is made separately for each detector, and `det_sens` carries detector i in bits [2i+1:2i].
- R5: The sensitivity word stores bits 15:0 and 31:24 as written. Bits 23:16 read 0.
- R6: While the lock value is nonzero, writes to the arm, disarm and sensitivity words are ignored. Writes to the trigger flag and force words still act.
- R7: A write of 0 to the lock word while unlocked leaves the bank unlocked. Once the lock value is nonzero, no write changes it (it reads back the first nonzero value in bits 7:0). Only reset clears it.
- R8: A raw trigger bit that is high at a clock edge while armed sets the matching flag in bits 3:0 of word 4. The flag stays set, and `alarm` is high while any flag is set.
- R9: Writing 1 to a flag bit clears it. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: Writing bits 3:0 of word 5 while armed sets the selected flags, exactly as raw triggers would. Word 5 always reads 0.
- R11: While `armed` is 0, neither raw nor forced triggers set any flag.
- R12: Word indices 6 and 7 read 0 and writes to them change nothing. Unused bits of the mapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| nv_arm_en | input | 1 | Nonvolatile arm default |
| nv_sens | input | 8 | Nonvolatile sensitivity defaults, 2 bits per detector |
| det_raw | input | 4 | Raw detector trigger outputs |
| armed | output | 1 | Effective arm state |
| det_sens | output | 8 | Effective sensitivity, 2 bits per detector |
| alarm | output | 1 | High while any trigger flag is set |

## Verification
The bench targets four corner cases.

- Arm and disarm key overlap. A design with the wrong priority disarms while a forced arm is present.
- Sensitivity pairs where only some detectors carry a correct complement. A design that validates the whole field at once, or compares against the wrong bits, would switch detectors it should not.
- A set and a clear on the same flag in the same cycle. A design that gives priority to the clear loses a trigger.
- The lock, including a zero write before sealing and attempts to overwrite or clear it afterwards. A design with a leaky lock lets frozen registers change or unseals itself.

Forced and raw triggers are also driven while disarmed, where any flag that appears marks a missing arm gate.

// File: rtl/gdet_pkg.sv
package gdet_pkg;

    typedef enum logic {
        LK_OPEN,
        LK_SEALED
    } lock_st_t;

    typedef enum logic [1:0] {
        SRC_NV,
        SRC_FORCE_ON,
        SRC_FORCE_OFF
    } arm_src_t;

    localparam int W_ARM    = 0;
    localparam int W_DISARM = 1;
    localparam int W_SENS   = 2;
    localparam int W_LOCK   = 3;
    localparam int W_STAT   = 4;
    localparam int W_FORCE  = 5;

endpackage

// File: rtl/gdet_lock_fsm.sv
module gdet_lock_fsm
    import gdet_pkg::*;
#(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [LOCK_W-1:0] lock_wdata,
    output logic [LOCK_W-1:0] lock_val,
    output logic              wr_open
);

    lock_st_t          state_q;
    lock_st_t          state_d;
    logic [LOCK_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (lock_wr && (|lock_wdata)) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            val_q <= '0;
        else if (state_q == LK_OPEN && lock_wr) val_q <= lock_wdata;
    end

    always_comb begin
        wr_open  = (state_q == LK_OPEN);
        lock_val = val_q;
    end

endmodule

// File: rtl/gdet_arm_ctl.sv
module gdet_arm_ctl
    import gdet_pkg::*;
#(
    parameter int              KEY_W      = 16,
    parameter logic [KEY_W-1:0] ARM_KEY    = 16'h5BAD,
    parameter logic [KEY_W-1:0] DISARM_KEY = 16'hDCAF
) (
    input  logic [KEY_W-1:0] arm_val,
    input  logic [KEY_W-1:0] disarm_val,
    input  logic             nv_arm_en,
    output logic             armed
);

    arm_src_t src;

    always_comb begin
        if (arm_val != ARM_KEY)          src = SRC_FORCE_ON;
        else if (disarm_val == DISARM_KEY) src = SRC_FORCE_OFF;
        else                             src = SRC_NV;
    end

    always_comb begin
        case (src)
            SRC_FORCE_ON:  armed = 1'b1;
            SRC_FORCE_OFF: armed = 1'b0;
            default:       armed = nv_arm_en;
        endcase
    end

endmodule

// File: rtl/gdet_sens_sel.sv
module gdet_sens_sel #(
    parameter int NDET = 4,
    parameter int SW   = 2
) (
    input  logic [NDET*SW-1:0] sw_val,
    input  logic [NDET*SW-1:0] sw_inv,
    input  logic [NDET*SW-1:0] nv_sens,
    output logic [NDET*SW-1:0] eff_sens
);

    for (genvar i = 0; i < NDET; i++) begin : g_det
        logic [SW-1:0] v;
        logic [SW-1:0] n;
        assign v = sw_val[i*SW +: SW];
        assign n = sw_inv[i*SW +: SW];
        assign eff_sens[i*SW +: SW] = (n == ~v) ? v : nv_sens[i*SW +: SW];
    end

endmodule

// File: rtl/gdet_trig_bank.sv
module gdet_trig_bank #(
    parameter int NDET = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  logic [NDET-1:0] det_raw,
    input  logic [NDET-1:0] force_bits,
    input  logic [NDET-1:0] clr_bits,
    output logic [NDET-1:0] stat,
    output logic            alarm
);

    logic [NDET-1:0] set_bits;

    assign set_bits = (det_raw | force_bits) & {NDET{armed}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_bits) | set_bits;
    end

    assign alarm = |stat;

endmodule

// File: rtl/gdet_ctrl_bank.sv
module gdet_ctrl_bank
    import gdet_pkg::*;
#(
    parameter int              NDET       = 4,
    parameter int              SW         = 2,
    parameter int              KEY_W      = 16,
    parameter int              LOCK_W     = 8,
    parameter int              ADDR_W     = 5,
    parameter int              DW         = 32,
    parameter logic [KEY_W-1:0] ARM_KEY    = 16'h5BAD,
    parameter logic [KEY_W-1:0] DISARM_KEY = 16'hDCAF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               nv_arm_en,
    input  logic [NDET*SW-1:0] nv_sens,
    input  logic [NDET-1:0]    det_raw,
    output logic               armed,
    output logic [NDET*SW-1:0] det_sens,
    output logic               alarm
);

    localparam int SFW     = NDET * SW;
    localparam int INV_LSB = SFW;
    localparam int DEF_W   = 8;
    localparam int DEF_LSB = DW - DEF_W;

    logic [KEY_W-1:0]  arm_q;
    logic [KEY_W-1:0]  disarm_q;
    logic [SFW-1:0]    sens_val_q;
    logic [SFW-1:0]    sens_inv_q;
    logic [DEF_W-1:0]  sens_def_q;
    logic [LOCK_W-1:0] lock_val;
    logic              wr_open;
    logic [NDET-1:0]   trig_stat;
    logic [NDET-1:0]   force_bits;
    logic [NDET-1:0]   clr_bits;
    logic              we;
    int                word;
    logic              unused_bits;

    assign we          = bus_sel && bus_wr;
    assign word        = int'(bus_addr[ADDR_W-1:2]);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DEF_LSB-1:INV_LSB+SFW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q      <= ARM_KEY;
            disarm_q   <= '0;
            sens_val_q <= '0;
            sens_inv_q <= '0;
            sens_def_q <= '0;
        end else if (we && wr_open) begin
            if (word == W_ARM)    arm_q    <= bus_wdata[KEY_W-1:0];
            if (word == W_DISARM) disarm_q <= bus_wdata[KEY_W-1:0];
            if (word == W_SENS) begin
                sens_val_q <= bus_wdata[SFW-1:0];
                sens_inv_q <= bus_wdata[INV_LSB +: SFW];
                sens_def_q <= bus_wdata[DEF_LSB +: DEF_W];
            end
        end
    end

    assign force_bits = (we && word == W_FORCE) ? bus_wdata[NDET-1:0] : '0;
    assign clr_bits   = (we && word == W_STAT)  ? bus_wdata[NDET-1:0] : '0;

    gdet_lock_fsm #(.LOCK_W(LOCK_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (we && word == W_LOCK),
        .lock_wdata (bus_wdata[LOCK_W-1:0]),
        .lock_val   (lock_val),
        .wr_open    (wr_open)
    );

    gdet_arm_ctl #(.KEY_W(KEY_W), .ARM_KEY(ARM_KEY), .DISARM_KEY(DISARM_KEY)) u_arm (
        .arm_val    (arm_q),
        .disarm_val (disarm_q),
        .nv_arm_en  (nv_arm_en),
        .armed      (armed)
    );

    gdet_sens_sel #(.NDET(NDET), .SW(SW)) u_sens (
        .sw_val   (sens_val_q),
        .sw_inv   (sens_inv_q),
        .nv_sens  (nv_sens),
        .eff_sens (det_sens)
    );

    gdet_trig_bank #(.NDET(NDET)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .det_raw    (det_raw),
        .force_bits (force_bits),
        .clr_bits   (clr_bits),
        .stat       (trig_stat),
        .alarm      (alarm)
    );

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_ARM:    bus_rdata[KEY_W-1:0] = arm_q;
            W_DISARM: bus_rdata[KEY_W-1:0] = disarm_q;
            W_SENS: begin
                bus_rdata[SFW-1:0]         = sens_val_q;
                bus_rdata[INV_LSB +: SFW]  = sens_inv_q;
                bus_rdata[DEF_LSB +: DEF_W] = sens_def_q;
            end
            W_LOCK:   bus_rdata[LOCK_W-1:0] = lock_val;
            W_STAT:   bus_rdata[NDET-1:0]   = trig_stat;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gdet_ctrl_bank_chk.sv
module gdet_ctrl_bank_chk #(
    parameter int              NDET    = 4,
    parameter int              KEY_W   = 16,
    parameter int              LOCK_W  = 8,
    parameter int              ADDR_W  = 5,
    parameter int              DW      = 32,
    parameter logic [KEY_W-1:0] ARM_KEY = 16'h5BAD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NDET-1:0]   wdata_lo,
    input logic [DW-1:0]     bus_rdata,
    input logic              armed,
    input logic              alarm,
    input logic [KEY_W-1:0]  arm_q,
    input logic [LOCK_W-1:0] lock_val,
    input logic [NDET-1:0]   stat
);

    int              wd;
    logic [NDET-1:0] clr_m;

    assign wd    = int'(bus_addr[ADDR_W-1:2]);
    assign clr_m = (bus_sel && bus_wr && wd == 4) ? wdata_lo : '0;

    AST_ARM_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != ARM_KEY) |-> armed); // R2
    AST_LOCK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_val != '0 && bus_sel && bus_wr && wd == 0) |=> $stable(arm_q)); // R6
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_val != '0) |=> (lock_val == $past(lock_val))); // R7
    AST_ALARM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != '0) |-> alarm); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~$past(clr_m)) & ~stat) == '0)); // R9
    AST_FORCE_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wd == 5) |-> (bus_rdata == '0)); // R10
    AST_NO_SET_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed) |=> ((stat & ~$past(stat)) == '0)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wd >= 6) |-> (bus_rdata == '0)); // R12

endmodule

bind gdet_ctrl_bank gdet_ctrl_bank_chk #(
    .NDET(NDET), .KEY_W(KEY_W), .LOCK_W(LOCK_W), .ADDR_W(ADDR_W), .DW(DW), .ARM_KEY(ARM_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[NDET-1:0]),
    .bus_rdata (bus_rdata),
    .armed     (armed),
    .alarm     (alarm),
    .arm_q     (arm_q),
    .lock_val  (lock_val),
    .stat      (trig_stat)
);

// File: tb/gdet_ctrl_bank_test.sv
module gdet_ctrl_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nv_arm_en = 1'b0;
    logic [7:0]  nv_sens = 8'hE4;
    logic [3:0]  det_raw = '0;
    logic        armed;
    logic [7:0]  det_sens;
    logic        alarm;

    int total = 0;
    int bad = 0;
    bit running = 0;
    bit done = 0;

    logic [15:0] m_arm;
    logic [15:0] m_dis;
    logic [31:0] m_sens;
    logic [7:0]  m_lock;
    logic [3:0]  m_stat;

    gdet_ctrl_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nv_arm_en(nv_arm_en), .nv_sens(nv_sens), .det_raw(det_raw),
        .armed(armed), .det_sens(det_sens), .alarm(alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic m_armed();
        if (m_arm != 16'h5BAD) return 1'b1;
        if (m_dis == 16'hDCAF) return 1'b0;
        return nv_arm_en;
    endfunction

    function automatic logic [7:0] m_eff();
        logic [7:0] e;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] s;
            logic [1:0] v;
            s = m_sens[2*i +: 2];
            v = m_sens[8 + 2*i +: 2];
            e[2*i +: 2] = (v == ~s) ? s : nv_sens[2*i +: 2];
        end
        return e;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return {16'h0, m_arm};
            3'd1: return {16'h0, m_dis};
            3'd2: return m_sens;
            3'd3: return {24'h0, m_lock};
            3'd4: return {28'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_arm = 16'h5BAD; m_dis = '0; m_sens = '0; m_lock = '0; m_stat = '0;
        end else begin
            logic [3:0] setv;
            logic [3:0] clrv;
            logic       wen;
            wen  = bus_sel && bus_wr;
            setv = det_raw | ((wen && bus_addr[4:2] == 3'd5) ? bus_wdata[3:0] : 4'h0);
            if (!m_armed()) setv = 4'h0;
            clrv = (wen && bus_addr[4:2] == 3'd4) ? bus_wdata[3:0] : 4'h0;
            m_stat = (m_stat & ~clrv) | setv;
            if (wen && m_lock == 8'h0) begin
                case (bus_addr[4:2])
                    3'd0: m_arm  = bus_wdata[15:0];
                    3'd1: m_dis  = bus_wdata[15:0];
                    3'd2: m_sens = bus_wdata & 32'hFF00FFFF;
                    3'd3: m_lock = bus_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R2 model armed", {31'h0, armed}, {31'h0, m_armed()});
            chk("R4 model det_sens", {24'h0, det_sens}, {24'h0, m_eff()});
            chk("R8 model alarm", {31'h0, alarm}, {31'h0, |m_stat});
            chk("R12 model rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] v);
        det_raw = v;
        @(posedge clk); #1;
        det_raw = 4'h0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; running = 1;
        // R1 reset state
        rd_chk("R1 arm reset", 5'h00, 32'h00005BAD);
        rd_chk("R1 disarm reset", 5'h04, 32'h0);
        rd_chk("R1 sens reset", 5'h08, 32'h0);
        chk("R1 armed follows nv", {31'h0, armed}, 32'h0);
        chk("R1 sens follows nv", {24'h0, det_sens}, 32'hE4);
        chk("R1 alarm low", {31'h0, alarm}, 32'h0);
        // R11 raw trigger while disarmed
        pulse(4'hF);
        rd_chk("R11 raw ignored when disarmed", 5'h10, 32'h0);
        // R2 forced arm
        wr(5'h00, 32'h0000_0001);
        chk("R2 forced arm", {31'h0, armed}, 32'h1);
        wr(5'h00, 32'h0000_5BAD);
        chk("R2 back to default", {31'h0, armed}, 32'h0);
        nv_arm_en = 1'b1; #1;
        chk("R2 default armed", {31'h0, armed}, 32'h1);
        // R3 forced disarm and priority
        wr(5'h04, 32'h0000_DCAF);
        chk("R3 forced disarm", {31'h0, armed}, 32'h0);
        wr(5'h00, 32'h0000_1234);
        chk("R3 arm wins", {31'h0, armed}, 32'h1);
        wr(5'h00, 32'h0000_5BAD);
        chk("R3 disarm again", {31'h0, armed}, 32'h0);
        wr(5'h04, 32'h0000_0001);
        chk("R3 wrong key uses nv", {31'h0, armed}, 32'h1);
        // R4/R5 sensitivity override
        wr(5'h08, 32'hA5FF_8136);
        chk("R4 per-detector validation", {24'h0, det_sens}, 32'hF6);
        rd_chk("R5 sens readback", 5'h08, 32'hA500_8136);
        // R8 sticky raw trigger
        pulse(4'h4);
        rd_chk("R8 flag set", 5'h10, 32'h4);
        chk("R8 alarm high", {31'h0, alarm}, 32'h1);
        repeat (2) @(posedge clk); #1;
        rd_chk("R8 flag sticky", 5'h10, 32'h4);
        // R9 clear and set-wins
        wr(5'h10, 32'h4);
        rd_chk("R9 cleared", 5'h10, 32'h0);
        chk("R9 alarm low", {31'h0, alarm}, 32'h0);
        det_raw = 4'h2;
        wr(5'h10, 32'h2);
        det_raw = 4'h0;
        rd_chk("R9 set wins over clear", 5'h10, 32'h2);
        wr(5'h10, 32'hF);
        // R10 forced triggers
        wr(5'h14, 32'h9);
        rd_chk("R10 force sets flags", 5'h10, 32'h9);
        rd_chk("R10 force reads zero", 5'h14, 32'h0);
        wr(5'h10, 32'hF);
        // R11 forced while disarmed
        wr(5'h04, 32'h0000_DCAF);
        chk("R11 disarmed", {31'h0, armed}, 32'h0);
        wr(5'h14, 32'hF);
        pulse(4'hF);
        rd_chk("R11 force ignored", 5'h10, 32'h0);
        // R12 unmapped
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped 0x18", 5'h18, 32'h0);
        rd_chk("R12 unmapped 0x1C", 5'h1C, 32'h0);
        rd_chk("R12 arm unchanged", 5'h00, 32'h0000_5BAD);
        rd_chk("R12 disarm unchanged", 5'h04, 32'h0000_DCAF);
        rd_chk("R12 lock unchanged", 5'h0C, 32'h0);
        // R7 zero lock write keeps it open
        wr(5'h04, 32'h0);
        wr(5'h0C, 32'h0);
        wr(5'h00, 32'h0000_0002);
        rd_chk("R7 zero lock stays open", 5'h00, 32'h0000_0002);
        wr(5'h00, 32'h0000_5BAD);
        // R6 seal and guard
        wr(5'h0C, 32'hFFFF_FF5A);
        rd_chk("R6 lock value", 5'h0C, 32'h5A);
        wr(5'h00, 32'h0000_1111);
        rd_chk("R6 arm frozen", 5'h00, 32'h0000_5BAD);
        wr(5'h04, 32'h0000_DCAF);
        rd_chk("R6 disarm frozen", 5'h04, 32'h0);
        chk("R6 still armed", {31'h0, armed}, 32'h1);
        wr(5'h08, 32'h0);
        rd_chk("R6 sens frozen", 5'h08, 32'hA500_8136);
        wr(5'h14, 32'h1);
        rd_chk("R6 force works locked", 5'h10, 32'h1);
        wr(5'h10, 32'h1);
        rd_chk("R6 clear works locked", 5'h10, 32'h0);
        // R7 lock sticky
        wr(5'h0C, 32'h0);
        rd_chk("R7 lock not cleared", 5'h0C, 32'h5A);
        wr(5'h0C, 32'hFF);
        rd_chk("R7 lock not rewritten", 5'h0C, 32'h5A);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd_chk("R7 reset clears lock", 5'h0C, 32'h0);
        rd_chk("R1 arm after reset", 5'h00, 32'h0000_5BAD);
        repeat (2) @(posedge clk); #1;
        finish_run();
    end

endmodule